// File: doc/BRIEF.md
# Rectangular Frame-Memory Transfer Engine

This block moves a rectangle of 16-bit pixels between a 32-bit data port and a frame memory that is 1024 pixels wide and 512 lines tall. A transfer is launched by a single-cycle start strobe. The strobe carries a position word, a size word and a direction flag. The engine then steps through the rectangle one pixel per memory cycle, row by row. It produces one frame-memory address for each pixel.

In the write direction, 32-bit words are accepted through a valid/ready pair. Each word is split into two pixels. In the read direction, the engine fetches pixels from a synchronous RAM port with one cycle of read latency and packs them two to a word into a held read register. The consumer frees that register with an acknowledge. Data may arrive or be taken with arbitrary gaps, including in the middle of a row. The engine keeps its column offset and its current line across those gaps.

A read transfer holds a busy flag while addresses remain to be fetched. Every transfer that runs to its end raises a one-cycle completion pulse. An abort strobe ends the current transfer at once.

Top module: `fmem_rect_xfer`

## Requirements
- R1: The start column is taken from position bits 9:0 and the start line from position bits 24:16; the first pixel of a transfer is accessed at address line*1024 + column.
- R2: Width is decoded from size bits 9:0 as ((field − 1) mod 1024) + 1, so a field of 0 gives 1024 pixels per row.
- R3: Height is decoded from size bits 24:16 as ((field − 1) mod 512) + 1, so a field of 0 gives 512 rows.
- R4: Pixels are visited row-major. The address is (line*1024 + column + offset) mod 2^19, where the offset runs from 0 to width−1 and does not wrap at column 1023. The line advances by one modulo 512 after each row.
- R5: In a write, a word is taken only in a cycle where wr_valid and wr_ready are both high. Bits 15:0 are written first, then bits 31:16. A high half left over after the last pixel of the rectangle is dropped, and no further word is taken.
- R6: Gaps between data words, including gaps inside a row, change neither the sequence of addresses nor the pixel count.
- R7: In a read, rd_data carries the earlier pixel in bits 15:0 and the later pixel in bits 31:16. If the pixel count is odd, the final word has zero in bits 31:16. The first word is valid in the third cycle after the start cycle without any acknowledge, and rd_data holds steady while rd_valid is high and no rd_ack is given.
- R8: busy is high from the cycle after a read start until the last pixel address of that read has been issued. It is never high during a write.
- R9: done is a single-cycle pulse, given exactly once per transfer, in the cycle after the final pixel access.
- R10: abort takes priority over everything else. After it, there is no further memory access, busy, wr_ready and rd_valid are low, and no done pulse follows.
- R11: mem_we and mem_re are never high together, and neither is high outside an active transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch of a transfer |
| start_pos | input | 32 | Position word: column in 9:0, line in 24:16 |
| start_size | input | 32 | Size word: width field in 9:0, height field in 24:16 |
| start_rd | input | 1 | 1 = frame memory to port, 0 = port to frame memory |
| abort | input | 1 | Ends the current transfer immediately |
| wr_valid | input | 1 | Write data word offered |
| wr_data | input | 32 | Write data word, first pixel in bits 15:0 |
| wr_ready | output | 1 | Engine can take a write word this cycle |
| rd_data | output | 32 | Read word, first pixel in bits 15:0 |
| rd_valid | output | 1 | rd_data holds an untaken word |
| rd_ack | input | 1 | Consumer takes rd_data |
| mem_addr | output | 19 | Frame-memory pixel address |
| mem_we | output | 1 | Frame-memory write strobe |
| mem_wdata | output | 16 | Frame-memory write pixel |
| mem_re | output | 1 | Frame-memory read strobe, data returns next cycle |
| mem_rdata | input | 16 | Frame-memory read pixel |
| busy | output | 1 | Read transfer still fetching |
| done | output | 1 | One-cycle completion pulse |

## Verification
The write path is tried with several input patterns. A short even rectangle sent back to back confirms the position decode and the half order. An odd-width rectangle fed with pauses inside rows shows whether the offset survives a gap and whether the spare half is dropped. A rectangle that starts near the last column and the last line tells the line wrap at 512 apart from the address wrap at 2^19. Zero width and zero height fields tell the maximum-size decode apart from a plain truncation. Reads of an odd pixel count with slow acknowledges check the packing, the zero fill, the prefetch latency and the busy window. Aborts in the middle of a write and of a read show that all activity stops and that no completion pulse follows.

// File: rtl/fmem_rect_xfer.sv
module fmem_rect_xfer #(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int PW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2*PW-1:0]    start_pos,
  input  logic [2*PW-1:0]    start_size,
  input  logic               start_rd,
  input  logic               abort,
  input  logic               wr_valid,
  input  logic [2*PW-1:0]    wr_data,
  output logic               wr_ready,
  output logic [2*PW-1:0]    rd_data,
  output logic               rd_valid,
  input  logic               rd_ack,
  output logic [XW+YW-1:0]   mem_addr,
  output logic               mem_we,
  output logic [PW-1:0]      mem_wdata,
  output logic               mem_re,
  input  logic [PW-1:0]      mem_rdata,
  output logic               busy,
  output logic               done
);
  localparam int DW = 2 * PW;
  localparam int AW = XW + YW;

  logic          rdir;
  logic [XW-1:0] x0;
  logic [YW-1:0] y;
  logic [XW:0]   wid;
  logic [XW-1:0] off;
  logic [YW:0]   rows;
  logic [DW-1:0] wbuf;
  logic [1:0]    wcnt;
  logic [1:0]    rph;
  logic [DW-1:0] rbuf;
  logic          rvld;
  logic          done_r;

  logic [XW-1:0] wm1;
  logic [YW-1:0] hm1;
  logic [XW:0]   wid_dec;
  logic [YW:0]   rows_dec;
  assign wm1      = start_size[XW-1:0] - XW'(1);
  assign hm1      = start_size[PW +: YW] - YW'(1);
  assign wid_dec  = {1'b0, wm1} + {{XW{1'b0}}, 1'b1};
  assign rows_dec = {1'b0, hm1} + {{YW{1'b0}}, 1'b1};

  logic live, wr_emit, rd_issue0, rd_issue1, step, row_end, last;
  logic [XW:0] col;

  assign live      = rows != '0;
  assign wr_emit   = !rdir && live && (wcnt != 2'd0);
  assign rd_issue0 = rdir && live && !rvld && (rph == 2'd0);
  assign rd_issue1 = rdir && live && (rph == 2'd1);
  assign step      = wr_emit || rd_issue0 || rd_issue1;
  assign row_end   = ({1'b0, off} + {{XW{1'b0}}, 1'b1}) == wid;
  assign last      = step && row_end && (rows == {{YW{1'b0}}, 1'b1});
  assign col       = {1'b0, x0} + {1'b0, off};

  assign mem_addr  = {y, {XW{1'b0}}} + {{(YW-1){1'b0}}, col};
  assign mem_we    = wr_emit;
  assign mem_re    = rd_issue0 || rd_issue1;
  assign mem_wdata = (wcnt == 2'd2) ? wbuf[PW-1:0] : wbuf[DW-1:PW];
  assign wr_ready  = !rdir && live && (wcnt == 2'd0);
  assign rd_data   = rbuf;
  assign rd_valid  = rvld;
  assign busy      = rdir && live;
  assign done      = done_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdir <= 1'b0; x0 <= '0; y <= '0; wid <= '0; off <= '0; rows <= '0;
      wbuf <= '0; wcnt <= 2'd0; rph <= 2'd0; rbuf <= '0; rvld <= 1'b0;
      done_r <= 1'b0;
    end else if (abort) begin
      rows <= '0; wcnt <= 2'd0; rph <= 2'd0; rvld <= 1'b0; done_r <= 1'b0;
    end else if (start) begin
      rdir <= start_rd;
      x0   <= start_pos[XW-1:0];
      y    <= start_pos[PW +: YW];
      wid  <= wid_dec;
      rows <= rows_dec;
      off  <= '0;
      wcnt <= 2'd0; rph <= 2'd0; rvld <= 1'b0; done_r <= 1'b0;
    end else begin
      done_r <= last;
      if (step) begin
        if (row_end) begin
          off  <= '0;
          y    <= y + {{(YW-1){1'b0}}, 1'b1};
          rows <= rows - {{YW{1'b0}}, 1'b1};
        end else begin
          off <= off + {{(XW-1){1'b0}}, 1'b1};
        end
      end
      if (wr_ready && wr_valid) begin
        wbuf <= wr_data;
        wcnt <= 2'd2;
      end else if (wr_emit) begin
        wcnt <= last ? 2'd0 : wcnt - 2'd1;
      end
      if (rd_ack && rvld) rvld <= 1'b0;
      case (rph)
        2'd0: if (rd_issue0) rph <= 2'd1;
        2'd1: begin
          rbuf[PW-1:0] <= mem_rdata;
          if (live) rph <= 2'd2;
          else begin
            rbuf[DW-1:PW] <= '0;
            rvld <= 1'b1;
            rph  <= 2'd0;
          end
        end
        2'd2: begin
          rbuf[DW-1:PW] <= mem_rdata;
          rvld <= 1'b1;
          rph  <= 2'd0;
        end
        default: rph <= 2'd0;
      endcase
    end
  end
endmodule

// File: rtl/fmem_rect_xfer_chk.sv
module fmem_rect_xfer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          abort,
  input logic          rd_ack,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          wr_ready,
  input logic          mem_we,
  input logic          mem_re,
  input logic          busy,
  input logic          done
);
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !wr_ready && !rd_valid && !mem_we && !mem_re && !done));

  assert_busy_not_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_we && !wr_ready);

  assert_ready_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !mem_we);

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ack && !abort && !start) |=> (rd_valid && $stable(rd_data)));
endmodule

bind fmem_rect_xfer fmem_rect_xfer_chk #(.DW(2*PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .rd_ack(rd_ack),
  .rd_valid(rd_valid), .rd_data(rd_data), .wr_ready(wr_ready),
  .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .done(done)
);

// File: tb/test_fmem_rect_xfer.sv
module test_fmem_rect_xfer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_pos = '0;
  logic [31:0] start_size = '0;
  logic        start_rd = 1'b0;
  logic        abort = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        rd_ack = 1'b0;
  logic [18:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic        mem_re;
  logic [15:0] mem_rdata = '0;
  logic        busy;
  logic        done;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmem_rect_xfer i_fmem_rect_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pos(start_pos),
    .start_size(start_size), .start_rd(start_rd), .abort(abort),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ack(rd_ack),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );

  int nchk = 0;
  int nerr = 0;
  logic [15:0] fmem [int];
  int exp_a[$];
  int exp_w[$];
  int exp_r[$];
  int nacc = 0;
  int first_addr = 0;
  int last_addr = 0;
  int ndone = 0;
  bit in_read = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] pix(input int a);
    if (fmem.exists(a)) return fmem[a];
    return 16'((a * 7 + 3) ^ 16'h5a5a);
  endfunction

  always @(posedge clk) begin
    if (mem_we) fmem[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= pix(int'(mem_addr));
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we && mem_re) chk(0, "R11 both strobes", 1, 0);
      if (mem_we || mem_re) begin
        if (exp_a.size() == 0) begin
          chk(0, "R11 access outside transfer", int'(mem_addr), -1);
        end else begin
          int a;
          a = exp_a.pop_front();
          if (nacc == 0) first_addr = int'(mem_addr);
          last_addr = int'(mem_addr);
          nacc++;
          chk(int'(mem_addr) == a, "R4 address", mem_addr, a);
          if (mem_we) begin
            int d;
            d = (exp_w.size() != 0) ? exp_w.pop_front() : -1;
            chk(int'(mem_wdata) == d, "R5 write pixel", mem_wdata, d);
          end
        end
      end
      if (done) ndone++;
      if (busy && !in_read) chk(0, "R8 busy during write", busy, 0);
    end
  end

  task automatic start_xfer(input int x0, input int y0, input int wf, input int hf, input bit rd);
    int w, h, n;
    w = ((wf - 1) & 1023) + 1;
    h = ((hf - 1) & 511) + 1;
    exp_a.delete(); exp_w.delete(); exp_r.delete();
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        exp_a.push_back(((((y0 + r) % 512) * 1024) + x0 + c) % 524288);
    n = exp_a.size();
    if (rd)
      for (int i = 0; i < n; i += 2)
        exp_r.push_back({(i + 1 < n) ? pix(exp_a[i+1]) : 16'h0, pix(exp_a[i])});
    nacc = 0; ndone = 0; in_read = rd;
    start_pos  = {7'b0, 9'(y0), 6'b0, 10'(x0)};
    start_size = {7'b0, 9'(hf), 6'b0, 10'(wf)};
    start_rd = rd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [31:0] d, input int gap);
    exp_w.push_back(int'(d[15:0]));
    exp_w.push_back(int'(d[31:16]));
    wr_data = d;
    wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic take(input int gap, input string tag);
    int e;
    while (!rd_valid) @(negedge clk);
    e = exp_r.pop_front();
    chk(rd_data == 32'(e), tag, rd_data, e);
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_xfer(input int npix);
    while (exp_a.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(ndone == 1, "R9 one done pulse", ndone, 1);
    chk(nacc == npix, "R6 pixel count", nacc, npix);
    chk(!busy && !wr_ready, "R11 idle after end", {busy, wr_ready}, 0);
    exp_w.delete();
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_ready && !rd_valid && !mem_we && !mem_re,
        "R11 reset state", {busy, done, wr_ready, rd_valid, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R5: even rectangle, back-to-back words
    start_xfer(100, 20, 4, 2, 0);
    for (int k = 0; k < 4; k++) send({16'(16'h1000 + 2*k + 1), 16'(16'h1000 + 2*k)}, 0);
    finish_xfer(8);
    chk(first_addr == 20*1024 + 100, "R1 first address", first_addr, 20*1024 + 100);

    // R5 R6: odd width, gaps inside rows, spare half dropped
    start_xfer(7, 40, 3, 3, 0);
    for (int k = 0; k < 5; k++) send({16'(16'h2000 + 2*k + 1), 16'(16'h2000 + 2*k)}, (k % 2) ? 5 : 1);
    finish_xfer(9);
    chk(exp_w.size() == 0 && !wr_ready, "R5 no word after end", wr_ready, 0);
    chk(last_addr == 42*1024 + 9, "R6 last address after gaps", last_addr, 42*1024 + 9);

    // R4: column past 1023 and line wrap at 512
    start_xfer(1020, 510, 8, 3, 0);
    for (int k = 0; k < 12; k++) send({16'(16'h3000 + 2*k + 1), 16'(16'h3000 + 2*k)}, k % 3);
    finish_xfer(24);
    chk(last_addr == 1027, "R4 wrap of address and line", last_addr, 1027);

    // R2: zero width field gives 1024 pixels
    start_xfer(0, 5, 0, 1, 0);
    for (int k = 0; k < 512; k++) send({16'(2*k + 1), 16'(2*k)}, 0);
    finish_xfer(1024);
    chk(nacc == 1024, "R2 width 1024", nacc, 1024);

    // R3: zero height field gives 512 rows
    start_xfer(33, 300, 1, 0, 0);
    for (int k = 0; k < 256; k++) send({16'(16'h8000 + 2*k + 1), 16'(16'h8000 + 2*k)}, 0);
    finish_xfer(512);
    chk(nacc == 512, "R3 height 512", nacc, 512);
    chk(last_addr == 299*1024 + 33, "R3 last row wraps", last_addr, 299*1024 + 33);

    // R7 R8: read with odd pixel count and slow acknowledges
    start_xfer(8, 3, 5, 3, 1);
    chk(busy, "R8 busy after read start", busy, 1);
    @(negedge clk);
    @(negedge clk);
    chk(!rd_valid, "R7 not valid before third cycle", rd_valid, 0);
    @(negedge clk);
    chk(rd_valid, "R7 first word in third cycle", rd_valid, 1);
    for (int k = 0; k < 8; k++) take(k % 4, "R7 read word");
    finish_xfer(15);
    chk(!rd_valid, "R7 nothing left", rd_valid, 0);

    // R7: read across the first written rectangle
    start_xfer(100, 20, 4, 2, 1);
    for (int k = 0; k < 4; k++) take(0, "R7 read back written data");
    finish_xfer(8);

    // R10: abort in the middle of a write
    start_xfer(200, 100, 16, 4, 0);
    for (int k = 0; k < 3; k++) send(32'h0bad_0bad + 32'(k), 0);
    repeat (4) @(negedge clk);
    exp_a.delete(); exp_w.delete();
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    repeat (12) @(negedge clk);
    chk(!wr_ready && !busy && !rd_valid, "R10 write abort quiet", {wr_ready, busy, rd_valid}, 0);
    chk(ndone == 0, "R10 no done after write abort", ndone, 0);

    // R10: abort in the middle of a read
    start_xfer(64, 64, 10, 10, 1);
    take(0, "R7 read before abort");
    while (!rd_valid) @(negedge clk);
    exp_a.delete(); exp_r.delete();
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    repeat (12) @(negedge clk);
    chk(!busy && !rd_valid, "R10 read abort quiet", {busy, rd_valid}, 0);
    chk(ndone == 0, "R10 no done after read abort", ndone, 0);

    report();
    $finish;
  end
endmodule